// File: doc/BRIEF.md
# Cascadable LCD Column Data Driver

This block is the digital core of a dot-matrix LCD column driver. Display data arrives four bits at a time on a shared bus, qualified by the falling edge of a shift clock. Each driver fills an 80-column line register one nibble per shift clock. A falling latch pulse then moves the whole line into a held output register. Every column turns its held bit and a frame-alternation level into a 2-bit drive-level code, and an analog level shifter outside this block turns that code into a voltage.

Several drivers share one data bus with no enable from the controller. Each driver listens only while its upstream chain input is low, takes exactly 20 nibbles, and then pulls its own chain output low to hand the bus to the next driver. A direction input reverses the column fill order. It also swaps which of the two bidirectional chain pins is the input and which is the output. Each chain pin appears as a separate input, output and output-enable.

The shift clock, latch pulse and frame input are synchronised to one fast system clock, and their falling edges are detected inside the block. This adds a fixed latency of a few system clocks to every action.

Top module: `lcd_col_driver`

## Requirements
- R1: After reset the fill count is zero, both the line register and the held register are all zero, and the frame level is low. Every column code is therefore 1, and the active chain output is high.
- R2: A nibble is taken on a shift-clock falling edge only while the active chain input is low. While that input is high, shifting changes nothing.
- R3: With direction low, nibble k (counting from 0) places D3, D2, D1, D0 on columns 79-4k, 78-4k, 77-4k, 76-4k.
- R4: With direction high, nibble k places D3, D2, D1, D0 on columns 4k, 4k+1, 4k+2, 4k+3.
- R5: With direction low, chain pin A is the output (a_oe=1) and pin B is the input. With direction high, pin B drives (b_oe=1) and pin A is the input. Exactly one enable is high at any time.
- R6: The active chain output stays high while fewer than 20 nibbles have been taken. It goes low after the 20th.
- R7: Once 20 nibbles have been taken, further shift edges leave the line register unchanged until the next latch.
- R8: A latch-pulse falling edge copies the line register into the held register, clears the fill count, and so drives the active chain output high again.
- R9: Column code = {frame, NOT(frame XOR held bit)}. With frame high, bit 1 gives 3 and bit 0 gives 2. With frame low, bit 1 gives 0 and bit 0 gives 1.
- R10: A frame toggle updates every column code without a latch pulse.
- R11: Between latch pulses the held columns do not change, however much data is shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Data shift clock, active on its falling edge |
| latch_pulse | input | 1 | Line latch, active on its falling edge |
| frame_in | input | 1 | Frame-alternation level |
| dir_sel | input | 1 | Fill direction and chain pin role select |
| nib_in | input | 4 | Display data nibble (bit 3 = D3) |
| chain_a_in | input | 1 | Chain pin A input value (used when dir_sel=1) |
| chain_a_out | output | 1 | Chain pin A drive value |
| chain_a_oe | output | 1 | Chain pin A output enable |
| chain_b_in | input | 1 | Chain pin B input value (used when dir_sel=0) |
| chain_b_out | output | 1 | Chain pin B drive value |
| chain_b_oe | output | 1 | Chain pin B output enable |
| col_code | output | 160 | Per-column drive codes, column c at bits [2c+1:2c] |

## Verification
A full line of distinct, non-symmetric nibbles is loaded in each direction. A wrong slot order, a wrong nibble bit order or a wrong direction decode therefore lands a different value on some column. Extra nibbles after the 20th, and nibbles sent while the chain input is high, must leave the line unchanged. A short partial line sent after the chain input is released must show that only the first slots were overwritten. Frame toggles with the held line fixed separate the frame path from the latch path.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;
  typedef logic [1:0] drv_code_t;

  localparam drv_code_t DRV_TOP    = 2'd0;
  localparam drv_code_t DRV_UPPER  = 2'd1;
  localparam drv_code_t DRV_LOWER  = 2'd2;
  localparam drv_code_t DRV_BOTTOM = 2'd3;

  function automatic drv_code_t drv_encode(input logic frame, input logic pix);
    drv_code_t c;
    case ({frame, pix})
      2'b11:   c = DRV_BOTTOM;
      2'b10:   c = DRV_LOWER;
      2'b01:   c = DRV_TOP;
      default: c = DRV_UPPER;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lcd_edge_sync.sv
module lcd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic fall
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign level = pipe_q[STAGES-1];
  assign fall  = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/lcd_line_loader.sv
module lcd_line_loader #(
  parameter int COLS = 80,
  parameter int NIB  = 4,
  localparam int NIBS = COLS / NIB,
  localparam int CW   = $clog2(NIBS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_fall,
  input  logic            latch_fall,
  input  logic            chain_in,
  input  logic            dir_sel,
  input  logic [NIB-1:0]  nib_in,
  output logic [COLS-1:0] line_q,
  output logic [CW-1:0]   fill_cnt,
  output logic            filling
);
  logic          accept;
  logic [CW-1:0] cnt_d;
  logic [NIB-1:0] nib_rev;

  assign filling = (fill_cnt < CW'(NIBS));
  assign accept  = shift_fall & ~chain_in & filling & ~latch_fall;

  generate
    for (genvar b = 0; b < NIB; b++) begin : g_rev
      assign nib_rev[b] = nib_in[NIB-1-b];
    end
  endgenerate

  always_comb begin
    cnt_d = fill_cnt;
    if (latch_fall)  cnt_d = '0;
    else if (accept) cnt_d = fill_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_cnt <= '0;
    else        fill_cnt <= cnt_d;
  end

  generate
    for (genvar j = 0; j < NIBS; j++) begin : g_slot
      logic           slot_we;
      logic [NIB-1:0] slot_d;
      assign slot_we = accept & (dir_sel ? (fill_cnt == CW'(j))
                                         : (fill_cnt == CW'(NIBS - 1 - j)));
      assign slot_d  = dir_sel ? nib_rev : nib_in;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line_q[j*NIB +: NIB] <= '0;
        else if (slot_we) line_q[j*NIB +: NIB] <= slot_d;
      end
    end
  endgenerate
endmodule

// File: rtl/lcd_col_output.sv
module lcd_col_output
  import lcd_col_pkg::*;
#(
  parameter int COLS = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_fall,
  input  logic              frame_lvl,
  input  logic [COLS-1:0]   line_q,
  output logic [COLS-1:0]   held_q,
  output logic [2*COLS-1:0] col_code
);
  logic [2*COLS-1:0] code_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held_q <= '0;
    else if (latch_fall) held_q <= line_q;
  end

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign code_d[2*c +: 2] = drv_encode(frame_lvl, held_q[c]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_code <= {COLS{DRV_UPPER}};
    else        col_code <= code_d;
  end
endmodule

// File: rtl/lcd_col_driver.sv
module lcd_col_driver #(
  parameter int COLS        = 80,
  parameter int NIB         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NIBS = COLS / NIB,
  localparam int CW   = $clog2(NIBS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_clk,
  input  logic              latch_pulse,
  input  logic              frame_in,
  input  logic              dir_sel,
  input  logic [NIB-1:0]    nib_in,
  input  logic              chain_a_in,
  output logic              chain_a_out,
  output logic              chain_a_oe,
  input  logic              chain_b_in,
  output logic              chain_b_out,
  output logic              chain_b_oe,
  output logic [2*COLS-1:0] col_code
);
  logic            shift_fall, latch_fall, frame_lvl;
  logic            shift_lvl, latch_lvl, frame_fall;
  logic            chain_in, filling;
  logic [CW-1:0]   fill_cnt;
  logic [COLS-1:0] line_q, held_q;

  lcd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_shift (
    .clk(clk), .rst_n(rst_n), .async_in(shift_clk),
    .level(shift_lvl), .fall(shift_fall));
  lcd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_latch (
    .clk(clk), .rst_n(rst_n), .async_in(latch_pulse),
    .level(latch_lvl), .fall(latch_fall));
  lcd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_frame (
    .clk(clk), .rst_n(rst_n), .async_in(frame_in),
    .level(frame_lvl), .fall(frame_fall));

  assign chain_in = dir_sel ? chain_a_in : chain_b_in;

  lcd_line_loader #(.COLS(COLS), .NIB(NIB)) i_loader (
    .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .latch_fall(latch_fall),
    .chain_in(chain_in), .dir_sel(dir_sel), .nib_in(nib_in),
    .line_q(line_q), .fill_cnt(fill_cnt), .filling(filling));

  lcd_col_output #(.COLS(COLS)) i_out (
    .clk(clk), .rst_n(rst_n), .latch_fall(latch_fall), .frame_lvl(frame_lvl),
    .line_q(line_q), .held_q(held_q), .col_code(col_code));

  assign chain_a_oe  = ~dir_sel;
  assign chain_b_oe  = dir_sel;
  assign chain_a_out = ~dir_sel & filling;
  assign chain_b_out = dir_sel & filling;

  logic unused_lvls;
  assign unused_lvls = shift_lvl ^ latch_lvl ^ frame_fall;
endmodule

// File: rtl/lcd_col_driver_chk.sv
module lcd_col_driver_chk #(
  parameter int COLS = 80,
  parameter int NIBS = 20,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dir_sel,
  input logic            chain_a_in,
  input logic            chain_b_in,
  input logic            chain_a_oe,
  input logic            chain_b_oe,
  input logic            latch_fall,
  input logic [CW-1:0]   fill_cnt,
  input logic [COLS-1:0] line_q,
  input logic [COLS-1:0] held_q
);
  p_cnt_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(NIBS));

  p_full_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(NIBS) && !latch_fall) |=> $stable(line_q));

  p_latch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fall |=> (fill_cnt == '0));

  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fall |=> $stable(held_q));

  p_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_fall && (dir_sel ? chain_a_in : chain_b_in)) |=> $stable(fill_cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fall |=> (fill_cnt == $past(fill_cnt) || fill_cnt == $past(fill_cnt) + CW'(1)));

  p_roles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({chain_a_oe, chain_b_oe}) == 1);
endmodule

bind lcd_col_driver lcd_col_driver_chk #(.COLS(COLS), .NIBS(NIBS), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel),
  .chain_a_in(chain_a_in), .chain_b_in(chain_b_in),
  .chain_a_oe(chain_a_oe), .chain_b_oe(chain_b_oe),
  .latch_fall(latch_fall), .fill_cnt(fill_cnt),
  .line_q(line_q), .held_q(held_q));

// File: tb/test_lcd_col_driver.sv
module test_lcd_col_driver;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 80;
  localparam int NIBS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b1, latch_pulse = 1'b0, frame_in = 1'b0, dir_sel = 1'b0;
  logic [3:0] nib_in = 4'h0;
  logic chain_a_in = 1'b0, chain_b_in = 1'b0;
  logic chain_a_out, chain_a_oe, chain_b_out, chain_b_oe;
  logic [2*COLS-1:0] col_code;

  int total = 0, bad = 0, quiet = 0;
  bit exp_line[COLS];
  bit exp_out[COLS];
  int exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_col_driver i_lcd_col_driver (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_pulse(latch_pulse),
    .frame_in(frame_in), .dir_sel(dir_sel), .nib_in(nib_in),
    .chain_a_in(chain_a_in), .chain_a_out(chain_a_out), .chain_a_oe(chain_a_oe),
    .chain_b_in(chain_b_in), .chain_b_out(chain_b_out), .chain_b_oe(chain_b_oe),
    .col_code(col_code));

  task automatic cmp(input string tag);
    logic [2*COLS-1:0] ev;
    logic [3:0] ech, ach;
    bit fill;
    for (int c = 0; c < COLS; c++) begin
      ev[2*c+1] = frame_in;
      ev[2*c]   = ~(frame_in ^ exp_out[c]);
    end
    fill = (exp_cnt < NIBS);
    ech = {~dir_sel, ~dir_sel & fill, dir_sel, dir_sel & fill};
    ach = {chain_a_oe, chain_a_out, chain_b_oe, chain_b_out};
    total++;
    if (col_code !== ev) begin
      bad++;
      $display("FAIL %s col_code actual=%h expected=%h", tag, col_code, ev);
    end
    total++;
    if (ach !== ech) begin
      bad++;
      $display("FAIL %s chain {a_oe,a_out,b_oe,b_out} actual=%b expected=%b", tag, ach, ech);
    end
  endtask

  // R11: outputs compared against the model on every settled clock
  always @(posedge clk) begin
    quiet++;
    #2;
    if (rst_n && quiet >= 6) cmp("R11");
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_shift(input logic [3:0] n);
    @(negedge clk);
    nib_in = n; quiet = 0;
    wait_clks(2);
    shift_clk = 1'b0; quiet = 0;
    if (!(dir_sel ? chain_a_in : chain_b_in) && exp_cnt < NIBS) begin
      for (int b = 0; b < 4; b++) begin
        if (!dir_sel) exp_line[76 - 4*exp_cnt + b] = n[b];
        else          exp_line[4*exp_cnt + 3 - b] = n[b];
      end
      exp_cnt++;
    end
    wait_clks(6);
    shift_clk = 1'b1; quiet = 0;
    wait_clks(6);
  endtask

  task automatic do_latch();
    @(negedge clk);
    latch_pulse = 1'b1; quiet = 0;
    wait_clks(6);
    latch_pulse = 1'b0; quiet = 0;
    for (int c = 0; c < COLS; c++) exp_out[c] = exp_line[c];
    exp_cnt = 0;
    wait_clks(7);
  endtask

  task automatic set_frame(input logic v);
    @(negedge clk);
    frame_in = v; quiet = 0;
    wait_clks(7);
  endtask

  task automatic set_ctl(input logic d, input logic ai, input logic bi);
    @(negedge clk);
    dir_sel = d; chain_a_in = ai; chain_b_in = bi; quiet = 0;
    wait_clks(7);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < COLS; c++) begin exp_line[c] = 0; exp_out[c] = 0; end
    wait_clks(5);
    rst_n = 1'b1; quiet = 0;
    wait_clks(7);
    cmp("R1 reset state");

    // direction low: fill full line, codes unchanged before latch
    set_ctl(1'b0, 1'b0, 1'b0);
    cmp("R5 dir low roles");
    for (int k = 0; k < NIBS - 1; k++) do_shift(4'((k * 7 + 3) % 16));
    cmp("R6 still filling after 19");
    do_shift(4'hC);
    cmp("R6 chain low after 20");
    cmp("R11 held unchanged before latch");
    do_shift(4'hF);
    do_shift(4'h0);
    cmp("R7 extra nibbles ignored");
    do_latch();
    cmp("R3 dir low mapping");
    cmp("R8 latch copies and rearms chain");

    // frame toggles without latch
    set_frame(1'b1);
    cmp("R10 frame high");
    cmp("R9 frame high codes");
    set_frame(1'b0);
    cmp("R9 frame low codes");

    // direction high
    set_ctl(1'b1, 1'b0, 1'b1);
    cmp("R5 dir high roles");
    for (int k = 0; k < NIBS; k++) do_shift(4'((k * 5 + 9) % 16));
    cmp("R6 dir high done");
    do_shift(4'h6);
    do_latch();
    cmp("R4 dir high mapping");
    cmp("R7 dir high extra ignored");
    set_frame(1'b1);
    cmp("R10 frame toggle after dir high");

    // chain input held high: shifting blocked
    set_ctl(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) do_shift(4'(k + 1));
    cmp("R2 blocked while chain input high");
    do_latch();
    cmp("R2 line unchanged when blocked");

    // released: partial line overwrites first slots only
    set_ctl(1'b1, 1'b0, 1'b0);
    do_shift(4'hA);
    do_shift(4'h3);
    do_shift(4'h8);
    cmp("R11 partial fill held");
    do_latch();
    cmp("R2 partial line after release");
    cmp("R4 partial mapping");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule